// File: doc/BRIEF.md
# Supply Monitor Control Register

This block is the software-facing control point for an on-chip supply voltage monitor. It sits on a simple 8-bit peripheral bus that carries an address, a write strobe, write data and read data. It holds two settings: a power-on switch for the analog comparator and a 4-bit code that picks the comparison threshold. Both settings are forwarded to the analog side unchanged.

The comparator's low-supply output is not shown live. The block resynchronizes it into the clock domain and stores it in a read-only result bit, but only when software switches the comparator from on to off. To take a reading, software turns the monitor on and waits for the settling time. It then turns the monitor off and reads the latched result.

An on-time counter, sized from the clock frequency, measures how long the monitor stayed on. A separate validity flag is latched at the same moment as the result. It reports whether the settling time had passed before the result was taken.

Top module: `vmon_ctrl`

## Requirements
- R1: After reset, the register reads 8'h00, `det_en_o` is 0, `det_thr_o` is 0 and `capt_valid_o` is 0.
- R2: The register byte is laid out as follows: threshold code in bits 3..0, monitor enable in bit 4, latched result in bit 5. Bits 7..6 always read as 0.
- R3: A write to the register address updates the threshold code and the enable. From the next clock, both values appear on `det_thr_o` and `det_en_o`, and they read back in the same positions.
- R4: The result bit is read-only. Writing 1 or 0 into bit 5 leaves the latched result unchanged.
- R5: A write that changes the enable from 1 to 0 loads the synchronized comparator output into the result bit. The result is 1 when the supply is below the threshold and 0 when it is at or above it.
- R6: The comparator input passes through a two-flop synchronizer. A comparator change is captured only if it was present at the two clock edges before the edge carrying the disabling write. A change that arrives together with that write is not captured.
- R7: The result holds its value while the enable is 1. It also holds when 0 is written while the enable is already 0.
- R8: The validity flag is loaded at each capture. It is set to 1 only if the enable had read as 1 for at least CLK_KHZ*MIN_ON_US/1000 clock cycles (16 at default parameters). The count restarts only on a 0-to-1 change of the enable; writing 1 while already on does not restart it.
- R9: Reads complete in the same cycle with no wait state. A read at any address other than the register address returns 8'h00.
- R10: The validity flag keeps its value until the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr_i | input | ADDR_W | Bus address |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from the address |
| det_en_o | output | 1 | Comparator power and detection enable |
| det_thr_o | output | 4 | Threshold code to the reference (1111 is the highest threshold) |
| det_low_i | input | 1 | Comparator output, asynchronous, 1 = supply low |
| capt_valid_o | output | 1 | Latched result was taken after the full settling time |

## Verification
The measurement cycle is exercised with a table of threshold codes, comparator levels and on-times. The on-times fall just under the settling limit, exactly on it and well past it. This separates correct capture of the result from correct judgement of the validity flag, including the off-by-one boundary. Directed sequences move the comparator level at chosen distances from the disabling write, which exposes a missing or extra synchronizer stage. They also rewrite the enable while it is already on or already off. Together these patterns show that the result is taken only on the falling enable and that the on-time count restarts only on a real turn-on.

// File: rtl/vmon_pkg.sv
package vmon_pkg;

    localparam int REG_W    = 8;
    localparam int THR_W    = 4;
    localparam int FLD_THR  = 0;
    localparam int FLD_EN   = 4;
    localparam int FLD_RES  = 5;

    typedef logic [THR_W-1:0] thr_t;
    typedef logic [REG_W-1:0] word_t;

    // Software-owned settings
    typedef struct packed {
        logic en;
        thr_t thr;
    } cfg_t;

    // Hardware-owned latched status
    typedef struct packed {
        logic low;
        logic ok;
    } capt_t;

    function automatic cfg_t unpack_cfg(word_t w);
        cfg_t c;
        c.en  = w[FLD_EN];
        c.thr = w[FLD_THR +: THR_W];
        return c;
    endfunction

    function automatic word_t pack_view(cfg_t c, capt_t s);
        word_t v;
        v                    = '0;
        v[FLD_THR +: THR_W]  = c.thr;
        v[FLD_EN]            = c.en;
        v[FLD_RES]           = s.low;
        return v;
    endfunction

    function automatic int unsigned min_on_cycles(int unsigned khz, int unsigned us);
        int unsigned r;
        r = (khz * us) / 1000;
        if (r < 1) r = 1;
        return r;
    endfunction

endpackage

// File: rtl/vmon_sync.sv
module vmon_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/vmon_ontimer.sv
module vmon_ontimer #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] CMAX = CW'(LIMIT);

    logic [CW-1:0] cnt;

    // Loaded with 1 on turn-on so that cnt equals the number of
    // cycles the enable has read as 1.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CW'(1);
        end else if (run && cnt != CMAX) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign done = (cnt == CMAX);
endmodule

// File: rtl/vmon_capture.sv
module vmon_capture
    import vmon_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  fire,
    input  logic  low,
    input  logic  ok,
    output capt_t st
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (fire) begin
            st.low <= low;
            st.ok  <= ok;
        end
    end
endmodule

// File: rtl/vmon_ctrl.sv
module vmon_ctrl
    import vmon_pkg::*;
#(
    parameter int              ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR  = 8'h34,
    parameter int unsigned     CLK_KHZ     = 32,
    parameter int unsigned     MIN_ON_US   = 500,
    parameter int              SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [7:0]        bus_wdata_i,
    output logic [7:0]        bus_rdata_o,
    output logic              det_en_o,
    output logic [3:0]        det_thr_o,
    input  logic              det_low_i,
    output logic              capt_valid_o
);
    localparam int unsigned MIN_CYC = min_on_cycles(CLK_KHZ, MIN_ON_US);

    cfg_t  cfg_q;
    cfg_t  cfg_new;
    capt_t st_q;
    logic  hit, wr, en_rise, en_fall;
    logic  low_sync, on_done;
    logic  res_q;
    logic  unused_wbits;

    assign hit     = (bus_addr_i == REG_ADDR);
    assign wr      = hit && bus_we_i;
    assign cfg_new = unpack_cfg(bus_wdata_i);
    assign en_rise = wr && cfg_new.en && !cfg_q.en;
    assign en_fall = wr && !cfg_new.en && cfg_q.en;
    assign unused_wbits = ^{bus_wdata_i[7:FLD_RES]};

    always_ff @(posedge clk) begin
        if (rst)     cfg_q <= '0;
        else if (wr) cfg_q <= cfg_new;
    end

    vmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (det_low_i),
        .q   (low_sync)
    );

    vmon_ontimer #(.LIMIT(MIN_CYC)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (en_rise),
        .run   (cfg_q.en),
        .done  (on_done)
    );

    vmon_capture u_capt (
        .clk  (clk),
        .rst  (rst),
        .fire (en_fall),
        .low  (low_sync),
        .ok   (on_done),
        .st   (st_q)
    );

    assign res_q        = st_q.low;
    assign det_en_o     = cfg_q.en;
    assign det_thr_o    = cfg_q.thr;
    assign capt_valid_o = st_q.ok;
    assign bus_rdata_o  = hit ? pack_view(cfg_q, st_q) : 8'h00;
endmodule

// File: rtl/vmon_ctrl_chk.sv
module vmon_ctrl_chk #(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h34
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [7:0]        bus_rdata_o,
    input logic              det_en_o,
    input logic [3:0]        det_thr_o,
    input logic              capt_valid_o,
    input logic              res_q,
    input logic              low_sync
);
    // R2
    a_r2_top_bits_zero: assert property (@(posedge clk) disable iff (rst)
        bus_rdata_o[7:6] == 2'b00);

    // R9
    a_r9_miss_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr_i != REG_ADDR) |-> (bus_rdata_o == 8'h00));

    // R3
    a_r3_thr_readback: assert property (@(posedge clk) disable iff (rst)
        (bus_addr_i == REG_ADDR) |-> (bus_rdata_o[3:0] == det_thr_o && bus_rdata_o[4] == det_en_o));

    // R5
    a_r5_capture_on_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(det_en_o) |-> (res_q == $past(low_sync)));

    // R7
    a_r7_result_holds: assert property (@(posedge clk) disable iff (rst)
        !$fell(det_en_o) |-> $stable(res_q));

    // R8
    a_r8_valid_only_at_fall: assert property (@(posedge clk) disable iff (rst)
        $rose(capt_valid_o) |-> (!det_en_o && $past(det_en_o)));

    // R10
    a_r10_valid_holds: assert property (@(posedge clk) disable iff (rst)
        !$fell(det_en_o) |-> $stable(capt_valid_o));
endmodule

bind vmon_ctrl vmon_ctrl_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_addr_i   (bus_addr_i),
    .bus_rdata_o  (bus_rdata_o),
    .det_en_o     (det_en_o),
    .det_thr_o    (det_thr_o),
    .capt_valid_o (capt_valid_o),
    .res_q        (res_q),
    .low_sync     (low_sync)
);

// File: tb/vmon_ctrl_test.sv
module vmon_ctrl_test;
    localparam int CLK_T = 10;
    localparam logic [7:0] RA = 8'h34;
    localparam int MIN_CYC = 32 * 500 / 1000;

    // entry: {thr[3:0], low, hold[7:0], exp_res, exp_ok}
    localparam logic [14:0] VEC [8] = '{
        {4'hF, 1'b1, 8'd20, 1'b1, 1'b1},
        {4'hD, 1'b0, 8'd20, 1'b0, 1'b1},
        {4'h0, 1'b1, 8'd14, 1'b1, 1'b0},
        {4'h5, 1'b0, 8'd15, 1'b0, 1'b1},
        {4'hA, 1'b1, 8'd15, 1'b1, 1'b1},
        {4'h3, 1'b0, 8'd0,  1'b0, 1'b0},
        {4'h8, 1'b1, 8'd30, 1'b1, 1'b1},
        {4'hE, 1'b0, 8'd14, 1'b0, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       det_en, capt_valid, det_low = 1'b0;
    logic [3:0] det_thr;

    int total = 0;
    int bad   = 0;
    logic [7:0] rv;

    always #(CLK_T/2) clk = ~clk;

    vmon_ctrl uut (
        .clk          (clk),
        .rst          (rst),
        .bus_addr_i   (bus_addr),
        .bus_we_i     (bus_we),
        .bus_wdata_i  (bus_wdata),
        .bus_rdata_o  (bus_rdata),
        .det_en_o     (det_en),
        .det_thr_o    (det_thr),
        .det_low_i    (det_low),
        .capt_valid_o (capt_valid)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    initial begin
        #(CLK_T * 200000);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        rd(RA, rv);
        check("R1 reg", rv, 8'h00);
        check("R1 en", {7'd0, det_en}, 8'h00);
        check("R1 thr", {4'd0, det_thr}, 8'h00);
        check("R1 valid", {7'd0, capt_valid}, 8'h00);

        // Table walk: R2 R3 R5 R8
        for (int i = 0; i < 8; i++) begin
            logic [3:0] t;
            logic       lo, er, eo;
            logic [7:0] h;
            {t, lo, h, er, eo} = VEC[i];
            det_low = lo;
            idle(3);
            wr(RA, {3'b000, 1'b1, t});
            check("R3 en out", {7'd0, det_en}, 8'h01);
            check("R3 thr out", {4'd0, det_thr}, {4'd0, t});
            idle(int'(h));
            wr(RA, {3'b000, 1'b0, t});
            rd(RA, rv);
            check("R2/R5 reg", rv, {2'b00, er, 1'b0, t});
            check("R8 valid", {7'd0, capt_valid}, {7'd0, eo});
            if ((int'(h) + 1 >= MIN_CYC) != eo) $display("table entry %0d inconsistent", i);
        end

        // R9 other addresses
        wr(RA, 8'h1B);
        rd(8'h00, rv); check("R9 miss 00", rv, 8'h00);
        rd(8'h35, rv); check("R9 miss 35", rv, 8'h00);
        rd(8'hFF, rv); check("R9 miss FF", rv, 8'h00);
        rd(RA, rv);    check("R9 hit", rv, 8'h1B);

        // capture a 1, valid
        det_low = 1'b1; idle(3);
        idle(20);
        wr(RA, 8'h02);
        rd(RA, rv); check("R5 low capture", rv, 8'h22);
        check("R8 valid long", {7'd0, capt_valid}, 8'h01);

        // R4 write 0 into result bit, R7 write 0 while off
        det_low = 1'b0; idle(3);
        wr(RA, 8'h07);
        rd(RA, rv); check("R4/R7 result kept", rv, 8'h27);
        check("R10 valid kept", {7'd0, capt_valid}, 8'h01);

        // capture 0 then R4 write 1 into result bit
        wr(RA, 8'h17); idle(20); wr(RA, 8'h07);
        rd(RA, rv); check("R5 high capture", rv, 8'h07);
        wr(RA, 8'h27);
        rd(RA, rv); check("R4 set ignored", rv, 8'h07);

        // R7 holds while enabled, R10 valid holds while enabled
        wr(RA, 8'h11);
        det_low = 1'b1; idle(25);
        rd(RA, rv); check("R7 hold while on", rv, 8'h11);
        check("R10 valid while on", {7'd0, capt_valid}, 8'h01);
        wr(RA, 8'h01);
        rd(RA, rv); check("R5 after hold", rv, 8'h21);

        // R6 synchronizer: change together with disabling write
        wr(RA, 8'h11); idle(20);
        det_low = 1'b0;
        wr(RA, 8'h01);
        rd(RA, rv); check("R6 same-edge not seen", rv, 8'h21);
        // one edge before: still old
        wr(RA, 8'h11); idle(20);
        det_low = 1'b1; idle(1);
        wr(RA, 8'h01);
        rd(RA, rv); check("R6 one-edge not seen", rv, 8'h01);
        // two edges before: new value
        wr(RA, 8'h11); idle(20);
        det_low = 1'b0; idle(2);
        wr(RA, 8'h01);
        rd(RA, rv); check("R6 two-edge seen", rv, 8'h01);
        wr(RA, 8'h11); idle(20);
        det_low = 1'b1; idle(2);
        wr(RA, 8'h01);
        rd(RA, rv); check("R6 two-edge seen rise", rv, 8'h21);

        // R8 rewrite of 1 does not restart the count
        wr(RA, 8'h14); idle(20); wr(RA, 8'h19); wr(RA, 8'h09);
        check("R8 no restart", {7'd0, capt_valid}, 8'h01);
        rd(RA, rv); check("R3 thr rewrite", rv, 8'h29);
        // real re-enable restarts the count
        wr(RA, 8'h19); idle(3); wr(RA, 8'h09);
        check("R8 restart short", {7'd0, capt_valid}, 8'h00);
        // R10 valid kept on redundant off write
        wr(RA, 8'h09);
        check("R10 valid low kept", {7'd0, capt_valid}, 8'h00);

        // R1 reset again clears everything
        rst = 1'b1; idle(2); rst = 1'b0; idle(1);
        rd(RA, rv); check("R1 re-reset", rv, 8'h00);
        check("R1 re-reset valid", {7'd0, capt_valid}, 8'h00);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule